// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an on-chip request port and an external asynchronous static RAM that holds 32K bytes. It turns one request at a time into the strobe sequence the memory needs. A request carries a 15-bit address, a byte of write data and a write flag. The block drives these memory pins:

- an address bus;
- an active-low select;
- an active-low read-drive enable;
- an active-low write strobe;
- an 8-bit data output, with a separate drive-enable for the pad's tristate buffer.

Read data comes back on the data input.

Each timing limit of the memory is a nanosecond parameter, and so is the clock period. At elaboration each limit becomes a whole number of clock cycles. The conversion rounds up and never gives less than one cycle. A fast or a slow memory grade is therefore chosen only by parameters.

On a write, the block keeps its own data drivers off for a float interval after the write strobe falls. This gives the memory time to release the bus. The read-drive enable stays high for the whole write, so the two sides never drive the bus at the same time.

Top module: `sram_ctl`

## Requirements
- R1: After reset the select, read-drive and write strobes are all high (1), the data drive-enable is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read request holds select and read-drive low, with the write strobe high, for exactly N_RD cycles. N_RD is the largest of ceil(t/CLK_NS), minimum 1, taken over the read cycle time, the address access time and the read-drive access time. The address stays stable for the whole interval.
- R3: The byte on `sram_dq_i` in the last strobe cycle of a read is returned on `rsp_rdata`. `rsp_valid` is high for exactly one cycle, N_RD+1 cycles after the accepting clock edge.
- R4: A write holds select and the write strobe low, with read-drive high throughout. The strobe stays low for exactly N_HZ+N_DRV cycles, which is at least the cycle count of the larger of the strobe-width and address-setup limits.
- R5: For the first N_HZ cycles of a write strobe the data drive-enable stays 0, where N_HZ is the cycle count of the output float limit. After that the data is driven for N_DRV cycles, with N_DRV at least the cycle count of the data-setup limit, before the strobe rises.
- R6: Select and the write strobe rise together. Address and write data are then held, with drivers still on, for one more cycle, and the drivers are off in the cycle after that.
- R7: The data drive-enable is never 1 while read-drive is low.
- R8: `req_ready` is 1 only while all strobes are high and the drivers are off. Between two accesses there is therefore at least one cycle with every strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| sram_addr | output | 15 | Memory address |
| sram_ce_n | output | 1 | Memory select, active low |
| sram_oe_n | output | 1 | Memory read-drive enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_dq_o | output | 8 | Data to the memory |
| sram_dq_oe | output | 1 | Tristate enable for `sram_dq_o` |
| sram_dq_i | input | 8 | Data from the memory |

## Verification
The driver records the edge on which each request is accepted. For a read, it queues the expected byte with a due cycle N_RD+1 edges later. The scoreboard samples on falling edges and compares both the data and the cycle in which `rsp_valid` appears.

A bus-level memory model counts strobe-low cycles, also on falling edges. At each rising strobe it checks the exact widths: N_RD for reads and N_HZ+N_DRV for writes. It also checks the float, drive and hold windows in the cycles given by R5 and R6, and on every cycle it checks that the model and the controller never drive the bus together.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WFLOAT,
        ST_WDRIVE,
        ST_WHOLD
    } sram_st_e;

    // nanoseconds to clock cycles: round up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_wait.sv
module sram_ctl_wait #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned AW    = 15,
    parameter int unsigned DW    = 8,
    parameter int unsigned CW    = 3,
    parameter int unsigned N_RD  = 2,
    parameter int unsigned N_HZ  = 1,
    parameter int unsigned N_DRV = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe,
    input  logic [DW-1:0] dq_i,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    input  logic          tmr_done
);
    localparam int unsigned N_WE = N_HZ + N_DRV;

    typedef struct packed {
        sram_st_e      st;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          rvalid;
        logic          ce_n;
        logic          oe_n;
        logic          we_n;
        logic          dq_oe;
    } seq_s;

    seq_s r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.rvalid = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.ce_n  = 1'b0;
                    tmr_load  = 1'b1;
                    if (req_write) begin
                        r_d.st   = ST_WFLOAT;
                        r_d.we_n = 1'b0;
                        tmr_val  = CW'(N_HZ - 1);
                    end else begin
                        r_d.st   = ST_READ;
                        r_d.oe_n = 1'b0;
                        tmr_val  = CW'(N_RD - 1);
                    end
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    r_d.rdata  = dq_i;
                    r_d.rvalid = 1'b1;
                    r_d.ce_n   = 1'b1;
                    r_d.oe_n   = 1'b1;
                    r_d.st     = ST_IDLE;
                end
            end
            ST_WFLOAT: begin
                if (tmr_done) begin
                    r_d.dq_oe = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(N_DRV - 1);
                    r_d.st    = ST_WDRIVE;
                end
            end
            ST_WDRIVE: begin
                if (tmr_done) begin
                    r_d.we_n = 1'b1;
                    r_d.ce_n = 1'b1;
                    r_d.st   = ST_WHOLD;
                end
            end
            ST_WHOLD: begin
                r_d.dq_oe = 1'b0;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.ce_n   <= 1'b1;
            r_q.oe_n   <= 1'b1;
            r_q.we_n   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign rsp_valid = r_q.rvalid;
    assign rsp_rdata = r_q.rdata;
    assign mem_addr  = r_q.addr;
    assign ce_n      = r_q.ce_n;
    assign oe_n      = r_q.oe_n;
    assign we_n      = r_q.we_n;
    assign dq_o      = r_q.wdata;
    assign dq_oe     = r_q.dq_oe;

    // strobe-width counters used only by the properties below
    logic [7:0] oe_low_d, oe_low_q, we_low_d, we_low_q;
    always_comb begin
        oe_low_d = oe_n ? 8'd0 : oe_low_q + 8'd1;
        we_low_d = we_n ? 8'd0 : we_low_q + 8'd1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_low_q <= '0;
            we_low_q <= '0;
        end else begin
            oe_low_q <= oe_low_d;
            we_low_q <= we_low_d;
        end
    end

    assert_read_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (oe_low_q == 8'(N_RD)));
    assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_write_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ce_n && oe_n));
    assert_write_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_low_q == 8'(N_WE)));
    assert_float_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> !dq_oe);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (dq_oe && $rose(ce_n)));
    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);
    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ce_n && oe_n && we_n && !dq_oe));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_NS  = 10,
    parameter int unsigned T_RC    = 20,
    parameter int unsigned T_AA    = 20,
    parameter int unsigned T_DOE   = 10,
    parameter int unsigned T_PWE   = 14,
    parameter int unsigned T_AW    = 14,
    parameter int unsigned T_SD    = 13,
    parameter int unsigned T_HZWE  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [14:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        rsp_valid,
    output logic [7:0]  rsp_rdata,
    output logic [14:0] sram_addr,
    output logic        sram_ce_n,
    output logic        sram_oe_n,
    output logic        sram_we_n,
    output logic [7:0]  sram_dq_o,
    output logic        sram_dq_oe,
    input  logic [7:0]  sram_dq_i
);
    localparam int unsigned AW    = 15;
    localparam int unsigned DW    = 8;
    localparam int unsigned N_RD  = umax(ns_to_cyc(T_RC, CLK_NS),
                                    umax(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_DOE, CLK_NS)));
    localparam int unsigned N_HZ  = ns_to_cyc(T_HZWE, CLK_NS);
    localparam int unsigned N_WMIN = ns_to_cyc(umax(T_PWE, T_AW), CLK_NS);
    localparam int unsigned N_DRV = umax(ns_to_cyc(T_SD, CLK_NS),
                                    (N_WMIN > N_HZ) ? (N_WMIN - N_HZ) : 1);
    localparam int unsigned N_MAX = umax(N_RD, umax(N_HZ, N_DRV));
    localparam int unsigned CW    = (N_MAX < 2) ? 1 : $clog2(N_MAX);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;

    sram_ctl_wait #(.CW(CW)) i_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctl_seq #(
        .AW(AW), .DW(DW), .CW(CW),
        .N_RD(N_RD), .N_HZ(N_HZ), .N_DRV(N_DRV)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (sram_addr),
        .ce_n      (sram_ce_n),
        .oe_n      (sram_oe_n),
        .we_n      (sram_we_n),
        .dq_o      (sram_dq_o),
        .dq_oe     (sram_dq_oe),
        .dq_i      (sram_dq_i),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_done  (tmr_done)
    );

endmodule

// File: tb/test_sram_ctl.sv
module test_sram_ctl;
    localparam int CLK_PERIOD = 10;
    // expected cycle counts for the default grade at a 10 ns clock
    localparam int E_RD  = 2;   // max(ceil 20/10, ceil 20/10, ceil 10/10)
    localparam int E_HZ  = 1;   // ceil 8/10
    localparam int E_DRV = 2;   // max(ceil 13/10, ceil 14/10 - 1)
    localparam int E_WE  = E_HZ + E_DRV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [14:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [7:0]  sram_dq_o, sram_dq_i;

    int vectors = 0, errors = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sram_ctl i_sram_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
        .sram_dq_i(sram_dq_i)
    );

    // ---------------- behavioural memory ----------------
    logic [7:0] mem [int];
    logic [7:0] ref_mem [int];
    logic       mem_drv;
    logic [7:0] mem_rd;

    function automatic logic [7:0] fill(input logic [14:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    always @* begin
        mem_drv = !sram_ce_n && !sram_oe_n && sram_we_n;
        mem_rd  = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : fill(sram_addr);
        sram_dq_i = mem_drv ? mem_rd : (sram_dq_oe ? sram_dq_o : 8'h00);
    end

    int         rlow = 0, wlow = 0, wdrv = 0, hold_chk = 0;
    logic [7:0] wlast;
    logic [14:0] waddr, raddr;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sram_dq_oe && mem_drv) begin
                errors++;
                $display("FAIL R7 bus contention at cycle %0d: oe_n=%b dq_oe=%b expected no overlap", cyc, sram_oe_n, sram_dq_oe);
            end
            if (hold_chk) begin
                vectors++;
                hold_chk = 0;
                if (sram_dq_oe !== 1'b0) begin
                    errors++;
                    $display("FAIL R6 drivers after hold: got %b expected 0", sram_dq_oe);
                end
            end
            // read strobes
            if (!sram_ce_n && !sram_oe_n) begin
                if (rlow == 0) raddr = sram_addr;
                rlow++;
                if (!sram_we_n || sram_addr !== raddr) begin
                    errors++;
                    $display("FAIL R2 read strobe state: we_n=%b addr=%h expected 1/%h", sram_we_n, sram_addr, raddr);
                end
            end else if (rlow != 0) begin
                vectors++;
                if (rlow != E_RD) begin
                    errors++;
                    $display("FAIL R2 read strobe width: got %0d expected %0d", rlow, E_RD);
                end
                rlow = 0;
            end
            // write strobes
            if (!sram_ce_n && !sram_we_n) begin
                if (wlow == 0) waddr = sram_addr;
                wlow++;
                if (!sram_oe_n) begin
                    errors++;
                    $display("FAIL R4 read-drive low during write: got %b expected 1", sram_oe_n);
                end
                if (sram_dq_oe) begin
                    wdrv++;
                    wlast = sram_dq_o;
                    if (wlow <= E_HZ) begin
                        errors++;
                        $display("FAIL R5 driven in float window: strobe cycle %0d expected > %0d", wlow, E_HZ);
                    end
                end
            end else if (wlow != 0) begin
                vectors++;
                if (wlow != E_WE || wdrv != E_DRV) begin
                    errors++;
                    $display("FAIL R4/R5 write widths: strobe %0d drive %0d expected %0d/%0d", wlow, wdrv, E_WE, E_DRV);
                end
                vectors++;
                if (!sram_ce_n || !sram_dq_oe || sram_addr !== waddr || sram_dq_o !== wlast) begin
                    errors++;
                    $display("FAIL R6 hold cycle: ce_n=%b dq_oe=%b addr=%h expected 1/1/%h", sram_ce_n, sram_dq_oe, sram_addr, waddr);
                end
                mem[int'(waddr)] = wlast;
                hold_chk = 1;
                wlow = 0;
                wdrv = 0;
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [7:0]  exp_q [$];
    logic [14:0] adr_q [$];
    int          due_q [$];

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            vectors++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3 unexpected response: got %h expected none", rsp_rdata);
            end else begin
                logic [7:0]  e;
                logic [14:0] a;
                int          d;
                e = exp_q.pop_front();
                a = adr_q.pop_front();
                d = due_q.pop_front();
                if (rsp_rdata !== e || cyc != d) begin
                    errors++;
                    $display("FAIL R3 read %h: got %h at cycle %0d expected %h at cycle %0d", a, rsp_rdata, cyc, e, d);
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input logic wr, input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        vectors++;
        if (!sram_ce_n === 1'b1 || !sram_oe_n || !sram_we_n || sram_dq_oe) begin
            errors++;
            $display("FAIL R8 ready while strobes active: ce/oe/we/oe=%b%b%b%b expected 1110", sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe);
        end
        if (wr) begin
            ref_mem[int'(a)] = d;
        end else begin
            exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : fill(a));
            adr_q.push_back(a);
            due_q.push_back(cyc + 1 + E_RD);
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        if (cyc == 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        vectors++;
        if (sram_ce_n !== 1 || sram_oe_n !== 1 || sram_we_n !== 1 || sram_dq_oe !== 0 ||
            req_ready !== 1 || rsp_valid !== 0) begin
            errors++;
            $display("FAIL R1 reset state: ce/oe/we/dq_oe/ready/rv=%b%b%b%b%b%b expected 111010",
                     sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready, rsp_valid);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        issue(1'b0, 15'h0123, 8'h00);     // unwritten location (R2, R3)
        issue(1'b1, 15'h0000, 8'hFF);     // lowest address (R4, R5, R6)
        issue(1'b1, 15'h7FFF, 8'h00);     // highest address
        issue(1'b0, 15'h0000, 8'h00);
        issue(1'b0, 15'h7FFF, 8'h00);
        issue(1'b1, 15'h2AAA, 8'h5A);
        issue(1'b1, 15'h2AAA, 8'hA5);     // overwrite
        issue(1'b0, 15'h2AAA, 8'h00);     // read after write back to back (R8)
        for (int i = 0; i < 16; i++) issue(1'b1, 15'(i * 37 + 5), 8'(i * 13 + 1));
        for (int i = 0; i < 16; i++) issue(1'b0, 15'(i * 37 + 5), 8'h00);
        for (int i = 0; i < 4; i++) begin
            issue(1'b0, 15'h1000, 8'h00);
            issue(1'b1, 15'h1000, 8'(i + 8'hC0));
        end
        issue(1'b0, 15'h1000, 8'h00);

        repeat (20) @(negedge clk);
        vectors++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R3 missing responses: got %0d pending expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule